// File: doc/BRIEF.md
# Mailbox Message Engine

This block is the host-side engine for framed byte messages exchanged with an embedded controller over a byte-wide mailbox. The mailbox reports a full flag for its write side and an empty flag for its read side. A message is a four-byte header (opcode, module identifier, then a 16-bit length, high byte first) followed by exactly that many payload bytes.

A one-cycle start pulse begins a transaction, and a direction bit chooses send or receive. A send writes the header built from the command fields and then takes the payload from a valid/ready byte stream. A receive reads a header and compares it with the expected opcode, module and length. On a match it passes the payload out on a valid/ready byte stream in arrival order. On a mismatch it reads and discards the number of bytes the received header announced, so the mailbox is left clean, and then reports the mismatch.

Every wait on a mailbox flag is polled at a fixed interval and abandoned after a limit. Both the interval and the limit are counted in clock cycles. Each transaction ends with a one-cycle done pulse and a 2-bit status.

Top module: `mbox_msg_engine`

## Requirements
- R1: A send writes the header to the mailbox in this order: opcode, module identifier, length bits 15:8, length bits 7:0.
- R2: After the header, a send writes exactly length payload bytes, in the order the send stream hands them over. A length of zero produces a header-only message with status ok (2'b00).
- R3: A byte is written only in a cycle where the full flag is low, and read only in a cycle where the empty flag is low. A write and a read never happen in the same cycle.
- R4: Only bits 7:0 of the mailbox read word form the received byte. The upper bits have no effect on any output.
- R5: When the received opcode, module and length all equal the expected values, the payload appears on the receive stream in arrival order, and the status is ok (2'b00). The stream holds its data stable while the consumer stalls.
- R6: When any header field differs, the block reads and discards exactly the announced number of bytes. No byte appears on the receive stream, and the status is mismatch (2'b01).
- R7: Each flag wait is polled every POLL_CYC cycles. After about TIMEOUT_CYC cycles without success the transaction ends with status timeout (2'b10) and no further mailbox access. This applies during a drain as well.
- R8: A start pulse that arrives while the block is busy is ignored.
- R9: busy rises in the cycle after an accepted start and stays high until the one-cycle done pulse. busy falls in the cycle after done.
- R10: During and straight after reset, busy, done, the mailbox strobes, the receive valid and the send ready are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transaction (accepted only when idle) |
| dir_rx | input | 1 | 1 = receive, 0 = send |
| cmd_opcode | input | 8 | Opcode to send or expect |
| cmd_module | input | 8 | Module identifier to send or expect |
| cmd_len | input | 16 | Payload length to send or expect |
| tx_data | input | 8 | Send payload byte |
| tx_valid | input | 1 | Send payload byte available |
| tx_ready | output | 1 | Send payload byte consumed this cycle |
| rx_data | output | 8 | Received payload byte |
| rx_valid | output | 1 | Received payload byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| mb_full | input | 1 | Mailbox write side full |
| mb_wr_en | output | 1 | Mailbox write strobe |
| mb_wr_data | output | 8 | Mailbox write byte |
| mb_empty | input | 1 | Mailbox read side empty |
| mb_rd_en | output | 1 | Mailbox read strobe (data taken this cycle) |
| mb_rd_data | input | RD_W | Mailbox read word, head of queue |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| status | output | 2 | 00 ok, 01 mismatch, 10 timeout; valid with done |

## Verification
A wrong byte index or length counter shows at the mailbox within one transaction. It appears as a misordered header, as one payload byte too many or too few in the sent log, or as a drain that leaves bytes behind in the mailbox, and it is visible by the cycle done rises. A wrong comparison shows as a status of mismatch where ok was due, or payload leaking onto the receive stream. A stuck wait counter shows as a timeout status arriving far outside its window, or a hang caught by the watchdog.

// File: rtl/mbox_pkg.sv
// Shared types for the mailbox message engine.
package mbox_pkg;
    localparam int HDR_BYTES = 4;

    typedef enum logic [1:0] {
        MB_OK       = 2'b00,
        MB_MISMATCH = 2'b01,
        MB_TIMEOUT  = 2'b10
    } mb_status_e;

    typedef enum logic [3:0] {
        S_IDLE, S_TX_HDR, S_TX_PAY, S_RX_HDR, S_RX_CHK,
        S_RX_PAY, S_RX_OUT, S_RX_DRAIN, S_FIN
    } mb_state_e;
endpackage

// File: rtl/mbox_poll_timer.sv
// Poll pacing and timeout for one mailbox flag wait.
// Assumes: clear is high whenever no wait is in progress; active low
// freezes the wait (stalled local stream) without losing progress.
module mbox_poll_timer #(
    parameter int POLL_CYC    = 4,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic active,
    input  logic flag_ok,
    output logic go,
    output logic tmo
);
    localparam int MAX_POLLS = (TIMEOUT_CYC + POLL_CYC - 1) / POLL_CYC;
    localparam int PW = $clog2(POLL_CYC + 1);
    localparam int FW = $clog2(MAX_POLLS + 1);

    logic [PW-1:0] phase;
    logic [FW-1:0] fails;
    logic          poll_now;

    // A poll happens on phase zero of each interval.
    assign poll_now = active && (phase == '0);
    assign go       = poll_now && flag_ok;
    assign tmo      = poll_now && !flag_ok && (fails == FW'(MAX_POLLS - 1));

    // Advance the interval phase and count failed polls.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || go || tmo) begin
            phase <= '0;
            fails <= '0;
        end else if (active) begin
            phase <= (phase == PW'(POLL_CYC - 1)) ? '0 : phase + 1'b1;
            if (poll_now) fails <= fails + 1'b1;
        end
    end
endmodule

// File: rtl/mbox_hdr_unit.sv
// Header byte selection for sends and header comparison for receives.
// Assumes: byte index 0..3 follows the wire order opcode, module, len hi, len lo.
module mbox_hdr_unit (
    input  logic [1:0]  idx,
    input  logic [7:0]  exp_op,
    input  logic [7:0]  exp_mod,
    input  logic [15:0] exp_len,
    input  logic [7:0]  got_op,
    input  logic [7:0]  got_mod,
    input  logic [15:0] got_len,
    output logic [7:0]  tx_byte,
    output logic        match
);
    // Pick the header byte for the current send position.
    always_comb begin
        unique case (idx)
            2'd0:    tx_byte = exp_op;
            2'd1:    tx_byte = exp_mod;
            2'd2:    tx_byte = exp_len[15:8];
            default: tx_byte = exp_len[7:0];
        endcase
    end

    assign match = (got_op == exp_op) && (got_mod == exp_mod) && (got_len == exp_len);
endmodule

// File: rtl/mbox_msg_engine.sv
// Host-side framer/checker for byte messages through a mailbox.
// Assumes: mb_rd_data shows the head byte while mb_empty is low and
// mb_rd_en pops it in that cycle; mb_wr_en pushes mb_wr_data.
module mbox_msg_engine
    import mbox_pkg::*;
#(
    parameter int POLL_CYC    = 4,
    parameter int TIMEOUT_CYC = 64,
    parameter int RD_W        = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            dir_rx,
    input  logic [7:0]      cmd_opcode,
    input  logic [7:0]      cmd_module,
    input  logic [15:0]     cmd_len,
    input  logic [7:0]      tx_data,
    input  logic            tx_valid,
    output logic            tx_ready,
    output logic [7:0]      rx_data,
    output logic            rx_valid,
    input  logic            rx_ready,
    input  logic            mb_full,
    output logic            mb_wr_en,
    output logic [7:0]      mb_wr_data,
    input  logic            mb_empty,
    output logic            mb_rd_en,
    input  logic [RD_W-1:0] mb_rd_data,
    output logic            busy,
    output logic            done,
    output logic [1:0]      status
);
    mb_state_e   state;
    logic [1:0]  idx;
    logic [15:0] cnt;
    logic [7:0]  c_op, c_mod;
    logic [15:0] c_len;
    logic [7:0]  rh [HDR_BYTES];
    logic [7:0]  hold;
    mb_status_e  stat;

    logic is_tx, in_wait, flag_ok, active, go, tmo, match;
    logic [7:0] hdr_byte;
    logic [RD_W-9:0] unused_hi;

    assign unused_hi = mb_rd_data[RD_W-1:8];

    assign is_tx   = (state == S_TX_HDR) || (state == S_TX_PAY);
    assign in_wait = is_tx || (state == S_RX_HDR) || (state == S_RX_PAY) ||
                     (state == S_RX_DRAIN);
    assign flag_ok = is_tx ? !mb_full : !mb_empty;
    assign active  = in_wait && ((state != S_TX_PAY) || tx_valid);

    mbox_poll_timer #(.POLL_CYC(POLL_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) timer_i (
        .clk(clk), .rst_n(rst_n), .clear(!in_wait), .active(active),
        .flag_ok(flag_ok), .go(go), .tmo(tmo)
    );

    mbox_hdr_unit hdr_i (
        .idx(idx), .exp_op(c_op), .exp_mod(c_mod), .exp_len(c_len),
        .got_op(rh[0]), .got_mod(rh[1]), .got_len({rh[2], rh[3]}),
        .tx_byte(hdr_byte), .match(match)
    );

    assign mb_wr_en   = go && is_tx;
    assign mb_wr_data = (state == S_TX_PAY) ? tx_data : hdr_byte;
    assign tx_ready   = go && (state == S_TX_PAY);
    assign mb_rd_en   = go && !is_tx;
    assign rx_valid   = (state == S_RX_OUT);
    assign rx_data    = hold;
    assign busy       = (state != S_IDLE);
    assign done       = (state == S_FIN);
    assign status     = stat;

    // Transaction sequencer: header, payload, check, drain, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            idx   <= '0;
            cnt   <= '0;
            c_op  <= '0;
            c_mod <= '0;
            c_len <= '0;
            hold  <= '0;
            stat  <= MB_OK;
            for (int i = 0; i < HDR_BYTES; i++) rh[i] <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    c_op  <= cmd_opcode;
                    c_mod <= cmd_module;
                    c_len <= cmd_len;
                    idx   <= '0;
                    state <= dir_rx ? S_RX_HDR : S_TX_HDR;
                end
                S_TX_HDR: if (tmo) begin
                    stat <= MB_TIMEOUT; state <= S_FIN;
                end else if (go) begin
                    idx <= idx + 1'b1;
                    if (idx == 2'd3) begin
                        cnt <= c_len;
                        if (c_len == '0) begin stat <= MB_OK; state <= S_FIN; end
                        else state <= S_TX_PAY;
                    end
                end
                S_TX_PAY: if (tmo) begin
                    stat <= MB_TIMEOUT; state <= S_FIN;
                end else if (go) begin
                    cnt <= cnt - 1'b1;
                    if (cnt == 16'd1) begin stat <= MB_OK; state <= S_FIN; end
                end
                S_RX_HDR: if (tmo) begin
                    stat <= MB_TIMEOUT; state <= S_FIN;
                end else if (go) begin
                    rh[idx] <= mb_rd_data[7:0];
                    idx     <= idx + 1'b1;
                    if (idx == 2'd3) state <= S_RX_CHK;
                end
                S_RX_CHK: if (match) begin
                    cnt <= c_len;
                    if (c_len == '0) begin stat <= MB_OK; state <= S_FIN; end
                    else state <= S_RX_PAY;
                end else begin
                    cnt <= {rh[2], rh[3]};
                    if ({rh[2], rh[3]} == 16'd0) begin stat <= MB_MISMATCH; state <= S_FIN; end
                    else state <= S_RX_DRAIN;
                end
                S_RX_PAY: if (tmo) begin
                    stat <= MB_TIMEOUT; state <= S_FIN;
                end else if (go) begin
                    hold  <= mb_rd_data[7:0];
                    state <= S_RX_OUT;
                end
                S_RX_OUT: if (rx_ready) begin
                    cnt <= cnt - 1'b1;
                    if (cnt == 16'd1) begin stat <= MB_OK; state <= S_FIN; end
                    else state <= S_RX_PAY;
                end
                S_RX_DRAIN: if (tmo) begin
                    stat <= MB_TIMEOUT; state <= S_FIN;
                end else if (go) begin
                    cnt <= cnt - 1'b1;
                    if (cnt == 16'd1) begin stat <= MB_MISMATCH; state <= S_FIN; end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mbox_msg_engine_chk.sv
// Port-level protocol checks for mbox_msg_engine, attached by bind.
module mbox_msg_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mb_full,
    input logic       mb_empty,
    input logic       mb_wr_en,
    input logic       mb_rd_en,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic [7:0] rx_data,
    input logic       busy,
    input logic       done,
    input logic [1:0] status
);
    assert_no_write_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mb_wr_en |-> !mb_full);
    assert_no_read_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mb_rd_en |-> !mb_empty);
    assert_one_direction_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mb_wr_en && mb_rd_en));
    assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    assert_busy_until_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    assert_status_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status != 2'b11));
endmodule

bind mbox_msg_engine mbox_msg_engine_chk chk_i (
    .clk(clk), .rst_n(rst_n), .mb_full(mb_full), .mb_empty(mb_empty),
    .mb_wr_en(mb_wr_en), .mb_rd_en(mb_rd_en), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .busy(busy), .done(done),
    .status(status)
);

// File: tb/mbox_msg_engine_tb_top.sv
// Self-checking bench: vector table walk, then directed corner cases.
module mbox_msg_engine_tb_top;
    localparam int CLK_PERIOD  = 10;
    localparam int POLL_CYC    = 4;
    localparam int TIMEOUT_CYC = 64;

    typedef struct packed {
        logic        dir;
        logic [7:0]  op;
        logic [7:0]  md;
        logic [15:0] len;
        logic [7:0]  rop;
        logic [7:0]  rmd;
        logic [15:0] rlen;
        logic [1:0]  st;
        logic [7:0]  seed;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h11, 8'h01, 16'd3,  8'h00, 8'h00, 16'd0,  2'b00, 8'h20},
        '{1'b0, 8'h22, 8'h02, 16'd0,  8'h00, 8'h00, 16'd0,  2'b00, 8'h30},
        '{1'b1, 8'h33, 8'h01, 16'd4,  8'h33, 8'h01, 16'd4,  2'b00, 8'h40},
        '{1'b1, 8'h44, 8'h01, 16'd2,  8'h45, 8'h01, 16'd5,  2'b01, 8'h50},
        '{1'b1, 8'h55, 8'h03, 16'd2,  8'h55, 8'h04, 16'd2,  2'b01, 8'h60},
        '{1'b1, 8'h66, 8'h01, 16'd3,  8'h66, 8'h01, 16'd6,  2'b01, 8'h70},
        '{1'b1, 8'h77, 8'h02, 16'd0,  8'h77, 8'h02, 16'd0,  2'b00, 8'h80}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, dir_rx = 1'b0;
    logic [7:0] cmd_opcode = '0, cmd_module = '0;
    logic [15:0] cmd_len = '0;
    logic [7:0] tx_data;
    logic tx_valid, tx_ready, rx_valid, rx_ready;
    logic [7:0] rx_data, mb_wr_data;
    logic mb_full, mb_empty, mb_wr_en, mb_rd_en;
    logic [31:0] mb_rd_data;
    logic busy, done;
    logic [1:0] status;

    // mailbox and stream models
    logic [7:0] src [64];
    logic [7:0] snk [64];
    logic [7:0] rxl [64];
    int src_n = 0, src_ptr = 0, snk_n = 0, rx_n = 0, tx_idx = 0, cyc = 0, done_n = 0;
    logic [7:0] tx_seed = '0;
    logic force_full = 1'b0, force_empty = 1'b0, clr = 1'b0;

    int checks = 0, errors = 0;
    bit finished = 0;

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return 8'(seed + 8'(i * 37));
    endfunction

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mb_full    = force_full;
    assign mb_empty   = force_empty || (src_ptr >= src_n);
    assign mb_rd_data = {24'hA5C3F0, src[src_ptr[5:0]]};
    assign tx_valid   = (cyc % 4) != 1;
    assign tx_data    = pat(tx_seed, tx_idx);
    assign rx_ready   = (cyc % 3) != 2;

    mbox_msg_engine #(.POLL_CYC(POLL_CYC), .TIMEOUT_CYC(TIMEOUT_CYC), .RD_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_rx(dir_rx),
        .cmd_opcode(cmd_opcode), .cmd_module(cmd_module), .cmd_len(cmd_len),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .mb_full(mb_full), .mb_wr_en(mb_wr_en), .mb_wr_data(mb_wr_data),
        .mb_empty(mb_empty), .mb_rd_en(mb_rd_en), .mb_rd_data(mb_rd_data),
        .busy(busy), .done(done), .status(status)
    );

    // Model state: mailbox pops/pushes, stream logs, done counter.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (clr) begin
            src_ptr <= 0; snk_n <= 0; rx_n <= 0; tx_idx <= 0; done_n <= 0;
        end else begin
            if (mb_wr_en) begin snk[snk_n[5:0]] <= mb_wr_data; snk_n <= snk_n + 1; end
            if (mb_rd_en) src_ptr <= src_ptr + 1;
            if (rx_valid && rx_ready) begin rxl[rx_n[5:0]] <= rx_data; rx_n <= rx_n + 1; end
            if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;
            if (done) done_n <= done_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_model();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic load_rx(input logic [7:0] op, input logic [7:0] md,
                           input logic [15:0] ln, input int npay, input logic [7:0] seed);
        src[0] = op; src[1] = md; src[2] = ln[15:8]; src[3] = ln[7:0];
        for (int i = 0; i < npay; i++) src[4 + i] = pat(seed, i);
        src_n = 4 + npay;
    endtask

    task automatic issue(input logic d, input logic [7:0] op, input logic [7:0] md,
                         input logic [15:0] ln);
        @(negedge clk);
        start = 1'b1; dir_rx = d; cmd_opcode = op; cmd_module = md; cmd_len = ln;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
        if (!done) check(1'b0, "R9 done never seen", 0, 1);
    endtask

    initial begin
        int n;
        // R10: reset state
        repeat (3) @(negedge clk);
        check(!busy && !done, "R10 busy/done in reset", {busy, done}, 0);
        check(!mb_wr_en && !mb_rd_en && !rx_valid && !tx_ready, "R10 strobes in reset",
              {mb_wr_en, mb_rd_en, rx_valid, tx_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mb_wr_en && !mb_rd_en, "R10 idle after reset", busy, 0);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            clear_model();
            tx_seed = VEC[v].seed;
            if (VEC[v].dir) load_rx(VEC[v].rop, VEC[v].rmd, VEC[v].rlen, int'(VEC[v].rlen), VEC[v].seed);
            else src_n = 0;
            issue(VEC[v].dir, VEC[v].op, VEC[v].md, VEC[v].len);
            check(busy, "R9 busy after start", busy, 1);
            wait_done(n);
            check(status == VEC[v].st, "R5/R6 status", status, VEC[v].st);
            @(negedge clk);
            check(!busy, "R9 busy after done", busy, 0);
            if (!VEC[v].dir) begin
                // R1/R2: header order and payload count
                check(snk_n == 4 + int'(VEC[v].len), "R2 bytes written", snk_n, 4 + int'(VEC[v].len));
                check(snk[0] == VEC[v].op && snk[1] == VEC[v].md, "R1 opcode/module", snk[0], VEC[v].op);
                check({snk[2], snk[3]} == VEC[v].len, "R1 length bytes", {snk[2], snk[3]}, VEC[v].len);
                for (int i = 0; i < int'(VEC[v].len); i++)
                    check(snk[4 + i] == pat(VEC[v].seed, i), "R2 payload byte", snk[4 + i], pat(VEC[v].seed, i));
            end else if (VEC[v].st == 2'b00) begin
                // R4/R5: payload in order, low byte only
                check(rx_n == int'(VEC[v].len), "R5 payload count", rx_n, int'(VEC[v].len));
                for (int i = 0; i < int'(VEC[v].len); i++)
                    check(rxl[i] == pat(VEC[v].seed, i), "R4 received byte", rxl[i], pat(VEC[v].seed, i));
            end else begin
                // R6: drained exactly, nothing streamed
                check(rx_n == 0, "R6 no payload out", rx_n, 0);
                check(src_ptr == src_n, "R6 mailbox drained", src_ptr, src_n);
            end
        end

        // R7: send times out on a stuck full flag
        clear_model();
        force_full = 1'b1; src_n = 0;
        issue(1'b0, 8'h91, 8'h01, 16'd2);
        wait_done(n);
        check(status == 2'b10, "R7 send timeout status", status, 2);
        check(n >= TIMEOUT_CYC - 2*POLL_CYC && n <= TIMEOUT_CYC + 2*POLL_CYC, "R7 timeout window", n, TIMEOUT_CYC);
        check(snk_n == 0, "R3 no write while full", snk_n, 0);
        force_full = 1'b0;

        // R7: receive times out on an empty mailbox
        clear_model();
        src_n = 0;
        issue(1'b1, 8'h92, 8'h01, 16'd1);
        wait_done(n);
        check(status == 2'b10, "R7 receive timeout status", status, 2);
        check(rx_n == 0, "R7 no output on timeout", rx_n, 0);

        // R7: drain stops early when the announced bytes never arrive
        clear_model();
        load_rx(8'h93, 8'h01, 16'd5, 2, 8'h11);
        issue(1'b1, 8'h94, 8'h01, 16'd5);
        wait_done(n);
        check(status == 2'b10, "R7 drain timeout status", status, 2);
        check(src_ptr == src_n, "R7 drain consumed available", src_ptr, src_n);

        // R8: start while busy is ignored
        clear_model();
        src_n = 0; tx_seed = 8'h05;
        force_full = 1'b1;
        issue(1'b0, 8'hAA, 8'h01, 16'd1);
        repeat (6) @(negedge clk);
        issue(1'b1, 8'h55, 8'h07, 16'd9);
        force_full = 1'b0;
        wait_done(n);
        check(status == 2'b00, "R8 first txn status", status, 0);
        repeat (30) @(negedge clk);
        check(snk_n == 5 && snk[0] == 8'hAA, "R8 second start ignored", snk_n, 5);
        check(done_n == 1 && !busy, "R8 single done", done_n, 1);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule